// File: doc/BRIEF.md
# UART FIFO watermark status controller

This block sits between a UART's software-visible register port and its serializer. It buffers up to eight outgoing bytes and up to eight incoming words. Each incoming word carries its own parity-error and framing-error bits through the buffer. Software pushes transmit bytes and pops receive words. The serializer pops transmit bytes and pushes received words.

Each direction raises a level interrupt when its fill level crosses a watermark. The watermark is picked by a 3-bit select code. The two directions count in opposite senses: free slots for transmit, held words for receive.

The block also keeps a sticky overflow error for software writes into a full transmit buffer, and sticky parity and framing error flags. While a channel is disabled, software can empty either buffer by writing one to that buffer's empty flag. A status byte gathers all the flags in one word.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset the status byte reads 0x16: both empty bits and the idle bit are 1, all other bits are 0. With both select codes at 0, tx_irq is 1 and rx_irq is 0.
- R2: Transmit bytes leave at ser_tx_data in the order software wrote them. Receive words, with their error bits, leave at rx_rd_data, rx_rd_perr and rx_rd_ferr in the order the serializer pushed them.
- R3: The status layout is: bit 0 rx full, bit 1 rx empty, bit 2 rx idle, bit 3 tx full, bit 4 tx empty, bit 5 write error, bit 6 parity error, bit 7 framing error. A buffer's empty bit is 1 exactly when it holds 0 entries. Its full bit is 1 exactly when it holds 8 entries.
- R4: A software write while the transmit buffer is full does two things: the byte is discarded, and the write-error bit is set. The bit stays set until a write of 0 to it; a write of 1 to it changes nothing.
- R5: tx_irq is 1 exactly when the number of free transmit slots is at least 8 minus tx_sel. It is recomputed every cycle.
- R6: rx_irq is 1 exactly when the receive buffer holds at least rx_sel plus 1 words, unless R7 holds it off.
- R7: rx_irq is 0 whenever the parity-error flag is set with perr_ie high, or the framing-error flag is set with ferr_ie high.
- R8: A cycle with tx_empty_wr high, tx_empty_wdata 1 and tx_enable low empties the transmit buffer and resets its pointers. rx_empty_wr with rx_empty_wdata 1 and rx_enable low does the same for the receive buffer.
- R9: An empty-flag write has no effect on the buffer if the channel is enabled, or if the written value is 0.
- R10: A push and a pop in the same cycle leave the fill level unchanged. A pop from an empty buffer is ignored and leaves the pointers intact.
- R11: Pushing a received word whose parity or framing bit is set sets the matching sticky flag. perr_clr or ferr_clr clears it.
- R12: The idle status bit shows the inverse of rx_busy, one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmit channel enabled |
| rx_enable | input | 1 | Receive channel enabled |
| tx_sel | input | 3 | Transmit watermark code |
| rx_sel | input | 3 | Receive watermark code |
| perr_ie | input | 1 | Parity-error interrupt enable |
| ferr_ie | input | 1 | Framing-error interrupt enable |
| tx_wr_en | input | 1 | Software writes a transmit byte |
| tx_wr_data | input | 8 | Transmit byte |
| rx_rd_en | input | 1 | Software pops the receive head |
| rx_rd_data | output | 8 | Receive head data |
| rx_rd_perr | output | 1 | Receive head parity-error bit |
| rx_rd_ferr | output | 1 | Receive head framing-error bit |
| tx_empty_wr | input | 1 | Software write to tx empty flag |
| tx_empty_wdata | input | 1 | Value written to tx empty flag |
| rx_empty_wr | input | 1 | Software write to rx empty flag |
| rx_empty_wdata | input | 1 | Value written to rx empty flag |
| werr_wr | input | 1 | Software write to write-error flag |
| werr_wdata | input | 1 | Value written to write-error flag |
| perr_clr | input | 1 | Clear parity-error flag |
| ferr_clr | input | 1 | Clear framing-error flag |
| ser_tx_pop | input | 1 | Serializer takes the transmit head |
| ser_tx_data | output | 8 | Transmit head byte |
| ser_tx_valid | output | 1 | Transmit buffer holds data |
| ser_rx_push | input | 1 | Serializer delivers a word |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_perr | input | 1 | Received word parity error |
| ser_rx_ferr | input | 1 | Received word framing error |
| rx_busy | input | 1 | Receive line activity |
| status | output | 8 | Status byte |
| tx_irq | output | 1 | Transmit watermark interrupt |
| rx_irq | output | 1 | Receive watermark interrupt |

## Verification
The bench sweeps every select code against every fill level from 0 to 8 in both directions. A watermark with an off-by-one would show up at one level, and so would swapped senses between transmit and receive. It writes into a full transmit buffer and then drains it. A design that stored the extra byte would return nine bytes, and one that dropped the sticky bit would read 0. Further checks cover the pointer reset under each gating combination, a push and a pop in the same cycle, a pop from an empty buffer, and interrupt hold-off by each error flag. A design that ignored the gating, slipped a pointer or leaked the held-off interrupt would return wrong head data or a wrong interrupt level.

// File: rtl/uart_fifo_pkg.sv
// Shared sizes, the received-word layout and status bit positions for the
// UART FIFO watermark status controller.
package uart_fifo_pkg;
    localparam int unsigned FIFO_DEPTH = 8;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int unsigned ST_RX_FULL  = 0;
    localparam int unsigned ST_RX_EMPTY = 1;
    localparam int unsigned ST_RX_IDLE  = 2;
    localparam int unsigned ST_TX_FULL  = 3;
    localparam int unsigned ST_TX_EMPTY = 4;
    localparam int unsigned ST_WERR     = 5;
    localparam int unsigned ST_PERR     = 6;
    localparam int unsigned ST_FERR     = 7;
endpackage

// File: rtl/fifo_ring.sv
// Circular buffer with a fill counter and a pointer flush.
// Assumes DEPTH is a power of two, so the pointers wrap by overflow.
// A push while full and a pop while empty are dropped. Flush wins over both.
module fifo_ring #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    // Accept only operations the current fill level allows.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= wdata;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    p_count_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);
    p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/uart_wm_irq.sv
// Watermark comparators for both directions.
// Transmit counts free slots against DEPTH minus the code. Receive counts
// held words against the code plus one. Assumes 2**SEL_W == DEPTH.
module uart_wm_irq #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned XW    = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [SEL_W-1:0] tx_sel,
    input  logic [SEL_W-1:0] rx_sel,
    input  logic             rx_hold,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH);
    logic [XW-1:0] free_slots, need_free, rx_need;

    // Level interrupts from the present fill levels and codes.
    always_comb begin
        free_slots = DEPTH_X - {1'b0, tx_cnt};
        need_free  = DEPTH_X - XW'(tx_sel);
        rx_need    = XW'(rx_sel) + XW'(1);
        tx_irq     = (free_slots >= need_free);
        rx_irq     = ({1'b0, rx_cnt} >= rx_need) && !rx_hold;
    end

    p_tx_empty_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0) |-> tx_irq);
    p_rx_full_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CNT_W'(DEPTH) && !rx_hold) |-> rx_irq);
    p_rx_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !rx_irq);
endmodule

// File: rtl/uart_fifo_status.sv
// UART FIFO watermark status controller top level.
// Holds the two buffers, the sticky error flags, the idle register and the
// status byte, and gates the software pointer resets on the channel enables.
module uart_fifo_status
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              rx_enable,
    input  logic [SEL_W-1:0]  tx_sel,
    input  logic [SEL_W-1:0]  rx_sel,
    input  logic              perr_ie,
    input  logic              ferr_ie,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_rd_perr,
    output logic              rx_rd_ferr,
    input  logic              tx_empty_wr,
    input  logic              tx_empty_wdata,
    input  logic              rx_empty_wr,
    input  logic              rx_empty_wdata,
    input  logic              werr_wr,
    input  logic              werr_wdata,
    input  logic              perr_clr,
    input  logic              ferr_clr,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    output logic              ser_tx_valid,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_rx_perr,
    input  logic              ser_rx_ferr,
    input  logic              rx_busy,
    output logic [7:0]        status,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             tx_flush, rx_flush, rx_hold, rx_accept;
    logic             werr_q, perr_q, ferr_q, idle_q;
    rx_word_t         rx_in, rx_head;

    // Decode software pointer resets and the accepted receive push.
    always_comb begin
        tx_flush  = tx_empty_wr && tx_empty_wdata && !tx_enable;
        rx_flush  = rx_empty_wr && rx_empty_wdata && !rx_enable;
        rx_in     = '{ferr: ser_rx_ferr, perr: ser_rx_perr, data: ser_rx_data};
        rx_accept = ser_rx_push && !rx_full && !rx_flush;
        rx_hold   = (perr_q && perr_ie) || (ferr_q && ferr_ie);
    end

    fifo_ring #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_wr_en), .pop(ser_tx_pop), .wdata(tx_wr_data),
        .rdata(ser_tx_data), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    fifo_ring #(.WIDTH($bits(rx_word_t)), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(ser_rx_push), .pop(rx_rd_en), .wdata(rx_in),
        .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    uart_wm_irq #(.DEPTH(FIFO_DEPTH), .SEL_W(SEL_W)) u_wm (
        .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_sel(tx_sel), .rx_sel(rx_sel), .rx_hold(rx_hold),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // Sticky error flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            werr_q <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            if (tx_wr_en && tx_full && !tx_flush) werr_q <= 1'b1;
            else if (werr_wr && !werr_wdata)      werr_q <= 1'b0;
            if (rx_accept && rx_in.perr)          perr_q <= 1'b1;
            else if (perr_clr)                    perr_q <= 1'b0;
            if (rx_accept && rx_in.ferr)          ferr_q <= 1'b1;
            else if (ferr_clr)                    ferr_q <= 1'b0;
        end
    end

    // Registered receive-line idle indication.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b1;
        else        idle_q <= !rx_busy;
    end

    // Output assembly.
    always_comb begin
        rx_rd_data   = rx_head.data;
        rx_rd_perr   = rx_head.perr;
        rx_rd_ferr   = rx_head.ferr;
        ser_tx_valid = !tx_empty;
        status              = '0;
        status[ST_RX_FULL]  = rx_full;
        status[ST_RX_EMPTY] = rx_empty;
        status[ST_RX_IDLE]  = idle_q;
        status[ST_TX_FULL]  = tx_full;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_WERR]     = werr_q;
        status[ST_PERR]     = perr_q;
        status[ST_FERR]     = ferr_q;
    end

    p_overflow_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && tx_full && !tx_flush) |=> werr_q);
    p_werr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (werr_q && !(werr_wr && !werr_wdata)) |=> werr_q);
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty_wr && tx_empty_wdata && !tx_enable) |=> tx_empty);
    p_flush_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty_wr && tx_enable && !tx_empty && !ser_tx_pop) |=> !tx_empty);
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((perr_q && perr_ie) || (ferr_q && ferr_ie)) |-> !rx_irq);
    p_idle_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (idle_q == !$past(rx_busy)));
endmodule

// File: tb/uart_fifo_status_bench.sv
// Sweep bench: every watermark code against every fill level, plus the
// overflow, flush gating, error hold-off and ordering corner cases.
module uart_fifo_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b1, rx_enable = 1'b1;
    logic [2:0] tx_sel = '0, rx_sel = '0;
    logic perr_ie = 1'b0, ferr_ie = 1'b0;
    logic tx_wr_en = 1'b0; logic [7:0] tx_wr_data = '0;
    logic rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data; logic rx_rd_perr, rx_rd_ferr;
    logic tx_empty_wr = 1'b0, tx_empty_wdata = 1'b0;
    logic rx_empty_wr = 1'b0, rx_empty_wdata = 1'b0;
    logic werr_wr = 1'b0, werr_wdata = 1'b0;
    logic perr_clr = 1'b0, ferr_clr = 1'b0;
    logic ser_tx_pop = 1'b0;
    logic [7:0] ser_tx_data; logic ser_tx_valid;
    logic ser_rx_push = 1'b0; logic [7:0] ser_rx_data = '0;
    logic ser_rx_perr = 1'b0, ser_rx_ferr = 1'b0;
    logic rx_busy = 1'b0;
    logic [7:0] status; logic tx_irq, rx_irq;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_status u_uart_fifo_status (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_wr_en = 1'b1; tx_wr_data = d; tick(); tx_wr_en = 1'b0;
    endtask

    task automatic pop_tx();
        ser_tx_pop = 1'b1; tick(); ser_tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d, input logic pe, input logic fe);
        ser_rx_push = 1'b1; ser_rx_data = d; ser_rx_perr = pe; ser_rx_ferr = fe;
        tick();
        ser_rx_push = 1'b0; ser_rx_perr = 1'b0; ser_rx_ferr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd_en = 1'b1; tick(); rx_rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 status", status, 8'h16);
        chk("R1 tx_irq", tx_irq, 1);
        chk("R1 rx_irq", rx_irq, 0);

        // R5 / R3 transmit sweep
        for (int k = 0; k <= 8; k++) begin
            for (int s = 0; s < 8; s++) begin
                tx_sel = 3'(s); #1;
                chk($sformatf("R5 k=%0d s=%0d", k, s), tx_irq, int'((8 - k) >= (8 - s)));
            end
            chk("R3 tx empty", status[4], int'(k == 0));
            chk("R3 tx full", status[3], int'(k == 8));
            if (k < 8) push_tx(8'hA0 + 8'(k));
        end
        push_tx(8'h5A);
        chk("R4 werr set", status[5], 1);
        chk("R4 still full", status[3], 1);
        for (int i = 0; i < 8; i++) begin
            chk("R2 tx order", ser_tx_data, 8'hA0 + i);
            pop_tx();
        end
        chk("R4 extra byte dropped", status[4], 1);
        werr_wr = 1'b1; werr_wdata = 1'b1; tick(); werr_wr = 1'b0;
        chk("R4 write one keeps", status[5], 1);
        werr_wr = 1'b1; werr_wdata = 1'b0; tick(); werr_wr = 1'b0;
        chk("R4 write zero clears", status[5], 0);
        tx_sel = '0;

        // R6 / R3 receive sweep
        for (int k = 0; k <= 8; k++) begin
            for (int s = 0; s < 8; s++) begin
                rx_sel = 3'(s); #1;
                chk($sformatf("R6 k=%0d s=%0d", k, s), rx_irq, int'(k >= s + 1));
            end
            chk("R3 rx empty", status[1], int'(k == 0));
            chk("R3 rx full", status[0], int'(k == 8));
            if (k < 8) push_rx(8'h30 + 8'(k), 1'b0, 1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            chk("R2 rx order", rx_rd_data, 8'h30 + i);
            chk("R2 rx perr bit", rx_rd_perr, 0);
            pop_rx();
        end
        chk("R3 rx drained", status[1], 1);
        rx_sel = '0;

        // R10 push and pop in one cycle
        push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
        tx_wr_en = 1'b1; tx_wr_data = 8'h04; ser_tx_pop = 1'b1; tick();
        tx_wr_en = 1'b0; ser_tx_pop = 1'b0;
        for (int i = 2; i <= 4; i++) begin
            chk("R10 level kept", status[4], 0);
            chk("R10 data", ser_tx_data, i);
            pop_tx();
        end
        chk("R10 three left", status[4], 1);
        // R10 pop from empty
        pop_tx();
        chk("R10 empty pop", status[4], 1);
        push_tx(8'h09);
        chk("R10 pointers intact", ser_tx_data, 8'h09);
        pop_tx();
        chk("R10 empty again", status[4], 1);
        pop_rx();
        push_rx(8'h44, 1'b0, 1'b0);
        chk("R10 rx pointers intact", rx_rd_data, 8'h44);
        pop_rx();

        // R8 / R9 transmit pointer reset
        for (int i = 0; i < 5; i++) push_tx(8'h10 + 8'(i));
        tx_empty_wr = 1'b1; tx_empty_wdata = 1'b1; tx_enable = 1'b1; tick();
        tx_empty_wr = 1'b0;
        chk("R9 enabled ignored", status[4], 0);
        chk("R9 enabled head", ser_tx_data, 8'h10);
        tx_enable = 1'b0;
        tx_empty_wr = 1'b1; tx_empty_wdata = 1'b0; tick(); tx_empty_wr = 1'b0;
        chk("R9 zero ignored", status[4], 0);
        chk("R9 zero head", ser_tx_data, 8'h10);
        tx_empty_wr = 1'b1; tx_empty_wdata = 1'b1; tick(); tx_empty_wr = 1'b0;
        chk("R8 tx flushed", status[4], 1);
        chk("R8 tx irq", tx_irq, 1);
        push_tx(8'h66);
        chk("R8 fresh head", ser_tx_data, 8'h66);
        pop_tx();
        chk("R8 single entry", status[4], 1);
        tx_enable = 1'b1;

        // R8 receive pointer reset
        for (int i = 0; i < 3; i++) push_rx(8'h20 + 8'(i), 1'b0, 1'b0);
        rx_enable = 1'b0;
        rx_empty_wr = 1'b1; rx_empty_wdata = 1'b1; tick(); rx_empty_wr = 1'b0;
        chk("R8 rx flushed", status[1], 1);
        chk("R8 rx irq", rx_irq, 0);
        rx_enable = 1'b1;

        // R7 / R11 error flags and hold-off
        push_rx(8'h77, 1'b1, 1'b0);
        chk("R11 perr flag", status[6], 1);
        chk("R11 perr carried", rx_rd_perr, 1);
        chk("R7 not enabled", rx_irq, 1);
        perr_ie = 1'b1; #1;
        chk("R7 perr holds off", rx_irq, 0);
        perr_clr = 1'b1; tick(); perr_clr = 1'b0;
        chk("R11 perr cleared", status[6], 0);
        chk("R7 released", rx_irq, 1);
        pop_rx();
        push_rx(8'h78, 1'b0, 1'b1);
        chk("R11 ferr flag", status[7], 1);
        chk("R11 ferr carried", rx_rd_ferr, 1);
        ferr_ie = 1'b1; #1;
        chk("R7 ferr holds off", rx_irq, 0);
        ferr_ie = 1'b0; #1;
        chk("R7 ferr not enabled", rx_irq, 1);
        ferr_clr = 1'b1; tick(); ferr_clr = 1'b0;
        chk("R11 ferr cleared", status[7], 0);
        pop_rx();

        // R12 idle
        rx_busy = 1'b1; tick();
        chk("R12 busy", status[2], 0);
        rx_busy = 1'b0; tick();
        chk("R12 idle", status[2], 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule